// File: doc/BRIEF.md
# Clock-Domain Scan Chain Router

This block sits between a chip's parallel scan pins and the scan chains of three clock-domain test groups. A two-bit test-mode select chooses which groups a scan pattern passes through. A single-group mode isolates one clock domain, so that the tester shifts and captures only that domain's flops. Daisy mode strings all of the groups into one long chain per lane.

Group A holds two blocks that run at one frequency. In every mode that uses group A, its two blocks are chained back to back. Groups B and C each hold a single block. Every port carries `LANES` parallel chains, one bit per chain. Lane i of any group links only to lane i of its neighbour. A group that is not on the selected path sees a constant 0 on its scan inputs.

The router is purely combinational and has no clock. The mode select is decoded once into a shared control word. A generate loop then builds one multiplexer cell per lane from that word. The modes form a small fixed set of routing states: GRP_A (00), GRP_B (01), GRP_C (10) and DAISY (11). A change of the select is the only transition between them, and it takes effect in the same time step.

Top module: `scan_domain_router`

## Requirements
- R1: The lane count `LANES` is a parameter, 8 by default. Every scan-in and scan-out port holds one bit per lane, bit i being lane i. A value on lane i of any input reaches only lane i of any output.
- R2: With mode_sel = 2'b00 (GRP_A), grp_a0_sin equals chip_sin, grp_a1_sin equals grp_a0_sout, and chip_sout equals grp_a1_sout.
- R3: With mode_sel = 2'b01 (GRP_B), grp_b_sin equals chip_sin and chip_sout equals grp_b_sout.
- R4: With mode_sel = 2'b10 (GRP_C), grp_c_sin equals chip_sin and chip_sout equals grp_c_sout.
- R5: With mode_sel = 2'b11 (DAISY), the chain runs chip_sin, then group A's first block, then its second block, then group B, then group C, then chip_sout. So grp_a0_sin = chip_sin, grp_a1_sin = grp_a0_sout, grp_b_sin = grp_a1_sout, grp_c_sin = grp_b_sout, and chip_sout = grp_c_sout.
- R6: Every group scan input that is not on the selected path is all zeros. This is group B and group C in GRP_A mode, both group A blocks and group C in GRP_B mode, and both group A blocks and group B in GRP_C mode.
- R7: All outputs follow their inputs in the same time step, with no register and no clock on any path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_sel | input | 2 | Routing mode: 00 GRP_A, 01 GRP_B, 10 GRP_C, 11 DAISY |
| chip_sin | input | LANES | Scan data from the chip scan-in pins |
| chip_sout | output | LANES | Scan data to the chip scan-out pins |
| grp_a0_sin | output | LANES | Scan-in of group A, first block |
| grp_a0_sout | input | LANES | Scan-out of group A, first block |
| grp_a1_sin | output | LANES | Scan-in of group A, second block |
| grp_a1_sout | input | LANES | Scan-out of group A, second block |
| grp_b_sin | output | LANES | Scan-in of group B |
| grp_b_sout | input | LANES | Scan-out of group B |
| grp_c_sin | output | LANES | Scan-in of group C |
| grp_c_sout | input | LANES | Scan-out of group C |

## Verification
For each of the four modes, the bench sweeps chip_sin through all 2^LANES values. Each group scan-out is driven at the same time with its own distinct function of that value: an XOR with a constant, a nibble swap, an inversion and a rotation. A swapped source, a wrong daisy order or a wrong tap therefore shows up as a value mismatch. One-hot and all-zero chip inputs are among the swept values. They show lane crossover (a bit reaching another lane) and any leakage into a gated group input, which must stay zero. Every output is sampled one time unit after its inputs change, with no clock edge in between, so an added register would be caught.

// File: rtl/scan_route_pkg.sv
package scan_route_pkg;

    typedef enum logic [1:0] {
        MODE_GRP_A = 2'b00,
        MODE_GRP_B = 2'b01,
        MODE_GRP_C = 2'b10,
        MODE_DAISY = 2'b11
    } route_mode_e;

    typedef enum logic [1:0] {
        FEED_ZERO     = 2'd0,
        FEED_PIN      = 2'd1,
        FEED_UPSTREAM = 2'd2
    } feed_e;

    typedef enum logic [1:0] {
        TAP_A1 = 2'd0,
        TAP_B  = 2'd1,
        TAP_C  = 2'd2
    } tap_e;

    typedef struct packed {
        feed_e feed_a0;
        feed_e feed_a1;
        feed_e feed_b;
        feed_e feed_c;
        tap_e  tap;
    } route_ctl_t;

endpackage

// File: rtl/scan_mode_decode.sv
module scan_mode_decode
    import scan_route_pkg::*;
(
    input  logic [1:0] mode_sel,
    output route_ctl_t ctl
);

    route_mode_e mode;

    assign mode = route_mode_e'(mode_sel);

    always_comb begin
        ctl = '{feed_a0: FEED_ZERO, feed_a1: FEED_ZERO, feed_b: FEED_ZERO,
                feed_c: FEED_ZERO, tap: TAP_A1};
        unique case (mode)
            MODE_GRP_A: begin
                ctl.feed_a0 = FEED_PIN;
                ctl.feed_a1 = FEED_UPSTREAM;
                ctl.tap     = TAP_A1;
            end
            MODE_GRP_B: begin
                ctl.feed_b  = FEED_PIN;
                ctl.tap     = TAP_B;
            end
            MODE_GRP_C: begin
                ctl.feed_c  = FEED_PIN;
                ctl.tap     = TAP_C;
            end
            MODE_DAISY: begin
                ctl.feed_a0 = FEED_PIN;
                ctl.feed_a1 = FEED_UPSTREAM;
                ctl.feed_b  = FEED_UPSTREAM;
                ctl.feed_c  = FEED_UPSTREAM;
                ctl.tap     = TAP_C;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/scan_lane_cell.sv
module scan_lane_cell
    import scan_route_pkg::*;
(
    input  route_ctl_t ctl,
    input  logic       pin_in,
    input  logic       a0_out,
    input  logic       a1_out,
    input  logic       b_out,
    input  logic       c_out,
    output logic       a0_in,
    output logic       a1_in,
    output logic       b_in,
    output logic       c_in,
    output logic       pin_out
);

    function automatic logic pick(feed_e f, logic pin, logic up);
        unique case (f)
            FEED_PIN:      return pin;
            FEED_UPSTREAM: return up;
            default:       return 1'b0;
        endcase
    endfunction

    always_comb begin
        a0_in = pick(ctl.feed_a0, pin_in, 1'b0);
        a1_in = pick(ctl.feed_a1, pin_in, a0_out);
        b_in  = pick(ctl.feed_b,  pin_in, a1_out);
        c_in  = pick(ctl.feed_c,  pin_in, b_out);
    end

    always_comb begin
        unique case (ctl.tap)
            TAP_B:   pin_out = b_out;
            TAP_C:   pin_out = c_out;
            default: pin_out = a1_out;
        endcase
    end

endmodule

// File: rtl/scan_domain_router.sv
module scan_domain_router
    import scan_route_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [1:0]       mode_sel,
    input  logic [LANES-1:0] chip_sin,
    output logic [LANES-1:0] chip_sout,
    output logic [LANES-1:0] grp_a0_sin,
    input  logic [LANES-1:0] grp_a0_sout,
    output logic [LANES-1:0] grp_a1_sin,
    input  logic [LANES-1:0] grp_a1_sout,
    output logic [LANES-1:0] grp_b_sin,
    input  logic [LANES-1:0] grp_b_sout,
    output logic [LANES-1:0] grp_c_sin,
    input  logic [LANES-1:0] grp_c_sout
);

    route_ctl_t ctl;

    scan_mode_decode u_decode (
        .mode_sel (mode_sel),
        .ctl      (ctl)
    );

    // R1: one cell per lane; lane i only touches bit i of every port
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        scan_lane_cell u_cell (
            .ctl     (ctl),
            .pin_in  (chip_sin[ln]),
            .a0_out  (grp_a0_sout[ln]),
            .a1_out  (grp_a1_sout[ln]),
            .b_out   (grp_b_sout[ln]),
            .c_out   (grp_c_sout[ln]),
            .a0_in   (grp_a0_sin[ln]),
            .a1_in   (grp_a1_sin[ln]),
            .b_in    (grp_b_sin[ln]),
            .c_in    (grp_c_sin[ln]),
            .pin_out (chip_sout[ln])
        );
    end

endmodule

// File: rtl/scan_route_checker.sv
module scan_route_checker #(
    parameter int LANES = 8
) (
    input logic [1:0]       mode_sel,
    input logic [LANES-1:0] chip_sin,
    input logic [LANES-1:0] chip_sout,
    input logic [LANES-1:0] grp_a0_sin,
    input logic [LANES-1:0] grp_a0_sout,
    input logic [LANES-1:0] grp_a1_sin,
    input logic [LANES-1:0] grp_a1_sout,
    input logic [LANES-1:0] grp_b_sin,
    input logic [LANES-1:0] grp_b_sout,
    input logic [LANES-1:0] grp_c_sin,
    input logic [LANES-1:0] grp_c_sout
);

    always_comb begin
        if (mode_sel == 2'b00) begin
            assert_grp_a_path_R2 : assert (grp_a0_sin == chip_sin &&
                grp_a1_sin == grp_a0_sout && chip_sout == grp_a1_sout);
            assert_grp_a_idle_R6 : assert (grp_b_sin == '0 && grp_c_sin == '0);
        end
        if (mode_sel == 2'b01) begin
            assert_grp_b_path_R3 : assert (grp_b_sin == chip_sin &&
                chip_sout == grp_b_sout);
            assert_grp_b_idle_R6 : assert (grp_a0_sin == '0 &&
                grp_a1_sin == '0 && grp_c_sin == '0);
        end
        if (mode_sel == 2'b10) begin
            assert_grp_c_path_R4 : assert (grp_c_sin == chip_sin &&
                chip_sout == grp_c_sout);
            assert_grp_c_idle_R6 : assert (grp_a0_sin == '0 &&
                grp_a1_sin == '0 && grp_b_sin == '0);
        end
        if (mode_sel == 2'b11) begin
            assert_daisy_order_R5 : assert (grp_a0_sin == chip_sin &&
                grp_a1_sin == grp_a0_sout && grp_b_sin == grp_a1_sout &&
                grp_c_sin == grp_b_sout && chip_sout == grp_c_sout);
        end
    end

endmodule

bind scan_domain_router scan_route_checker #(.LANES(LANES)) u_route_chk (
    .mode_sel    (mode_sel),
    .chip_sin    (chip_sin),
    .chip_sout   (chip_sout),
    .grp_a0_sin  (grp_a0_sin),
    .grp_a0_sout (grp_a0_sout),
    .grp_a1_sin  (grp_a1_sin),
    .grp_a1_sout (grp_a1_sout),
    .grp_b_sin   (grp_b_sin),
    .grp_b_sout  (grp_b_sout),
    .grp_c_sin   (grp_c_sin),
    .grp_c_sout  (grp_c_sout)
);

// File: tb/test_scan_domain_router.sv
`timescale 1ns/1ps
module test_scan_domain_router;

    localparam int K = 8;

    logic         clk = 1'b0;
    logic [1:0]   mode_sel;
    logic [K-1:0] chip_sin, chip_sout;
    logic [K-1:0] a0_sin, a0_sout, a1_sin, a1_sout;
    logic [K-1:0] b_sin, b_sout, c_sin, c_sout;

    int  n_vec  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    scan_domain_router #(.LANES(K)) i_scan_domain_router (
        .mode_sel    (mode_sel),
        .chip_sin    (chip_sin),
        .chip_sout   (chip_sout),
        .grp_a0_sin  (a0_sin),
        .grp_a0_sout (a0_sout),
        .grp_a1_sin  (a1_sin),
        .grp_a1_sout (a1_sout),
        .grp_b_sin   (b_sin),
        .grp_b_sout  (b_sout),
        .grp_c_sin   (c_sin),
        .grp_c_sout  (c_sout)
    );

    task automatic cmp(string req, string what, logic [K-1:0] act, logic [K-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s mode=%0d sin=%h actual=%h expected=%h",
                     req, what, mode_sel, chip_sin, act, exp);
        end
    endtask

    // Drive one vector; group outputs are distinct functions of v
    task automatic apply(logic [1:0] m, logic [K-1:0] v);
        mode_sel = m;
        chip_sin = v;
        a0_sout  = v ^ 8'h5A;
        a1_sout  = {v[3:0], v[7:4]};
        b_sout   = ~v;
        c_sout   = {v[K-2:0], v[K-1]};
        #1;  // R7: sampled with no clock edge in between
    endtask

    task automatic check_mode(logic [1:0] m, logic [K-1:0] v);
        logic [K-1:0] e_a0, e_a1, e_b, e_c, e_so;
        string rq;
        apply(m, v);
        case (m)
            2'b00: begin rq = "R2/R6/R7"; e_a0 = v; e_a1 = a0_sout; e_b = '0; e_c = '0; e_so = a1_sout; end
            2'b01: begin rq = "R3/R6/R7"; e_a0 = '0; e_a1 = '0; e_b = v; e_c = '0; e_so = b_sout; end
            2'b10: begin rq = "R4/R6/R7"; e_a0 = '0; e_a1 = '0; e_b = '0; e_c = v; e_so = c_sout; end
            default: begin rq = "R5/R7"; e_a0 = v; e_a1 = a0_sout; e_b = a1_sout; e_c = b_sout; e_so = c_sout; end
        endcase
        cmp(rq, "grp_a0_sin", a0_sin, e_a0);
        cmp(rq, "grp_a1_sin", a1_sin, e_a1);
        cmp(rq, "grp_b_sin",  b_sin,  e_b);
        cmp(rq, "grp_c_sin",  c_sin,  e_c);
        cmp(rq, "chip_sout",  chip_sout, e_so);
    endtask

    initial begin
        // quiet start: all-zero inputs give all-zero outputs in every mode
        for (int m = 0; m < 4; m++) begin
            mode_sel = 2'(m);
            chip_sin = '0; a0_sout = '0; a1_sout = '0; b_sout = '0; c_sout = '0;
            #1;
            cmp("R6", "quiet chip_sout", chip_sout, '0);
            cmp("R6", "quiet group inputs", a0_sin | a1_sin | b_sin | c_sin, '0);
        end
        // R1: walking one on each lane, other sources zero, daisy mode
        for (int ln = 0; ln < K; ln++) begin
            mode_sel = 2'b11;
            chip_sin = K'(1) << ln;
            a0_sout = '0; a1_sout = '0; b_sout = '0; c_sout = '0;
            #1;
            cmp("R1", "lane a0_sin", a0_sin, K'(1) << ln);
            cmp("R1", "lane other inputs", a1_sin | b_sin | c_sin, '0);
            c_sout = K'(1) << ln;
            #1;
            cmp("R1", "lane chip_sout", chip_sout, K'(1) << ln);
        end
        // exhaustive sweep R2..R7
        for (int m = 0; m < 4; m++)
            for (int v = 0; v < (1 << K); v++) begin
                @(negedge clk);
                check_mode(2'(m), K'(v));
            end
        // R7: mode change alone re-routes in the same time step
        apply(2'b01, 8'h3C);
        mode_sel = 2'b10;
        #1;
        cmp("R7", "switch chip_sout", chip_sout, c_sout);
        cmp("R7", "switch grp_b_sin", b_sin, '0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule